// File: doc/BRIEF.md
# Byte-Lane Sequenced Transfer Buffer

This block is the host-facing data port of a card-interface transfer buffer. It stores 256 words of 32 bits (1024 bytes) and splits them into two halves of 128 words each. The halves are used in alternation: the host fills or drains one half while the card side works on the other. The host reaches the whole buffer through one 32-bit access port. Each access carries a 4-bit byte-lane enable. An internal word pointer selects the word that the access touches.

Within one word the host may use narrow accesses, but the lanes must come in ascending order with no gaps, starting at lane 0. The pointer moves to the next word only when an access reaches lane 3. On the last word of a block it also moves when the access reaches the highest lane that the programmed byte count covers. An access is refused in four cases: the buffer is not enabled for that direction, the half is owned by the card side, the block has ended, or the lane order is broken. A refused access moves no data, leaves the pointer and lane state as they were, and sets a sticky bad-access flag.

Ownership of a half passes to the card side when the host finishes that half's last word or the block's last word. It comes back on a one-cycle done pulse for that half. The card side has a plain word-wide memory port. The host request port has no back-pressure: every cycle with `host_valid` high is one access and is consumed in that cycle. Each read access yields one response, `host_rsp_valid`, one cycle later. The host must not issue an access it cannot afford to have refused; it learns of a refusal only from the flag.

Top module: `xfer_byte_buffer`

## Requirements
- R1: After reset, `bad_access`, `half_to_card` and `host_rsp_valid` are 0. `buf_wr_en` and `buf_rd_en` are 0 until a transfer is started.
- R2: Byte lane k of a word is bits [8k+7:8k] of the host data and of the card-side word (little endian, lane 0 = bits [7:0]). A write stores exactly the enabled lanes of the current word.
- R3: Within one word, the first accepted access must have lane 0 as its lowest enabled lane. Each later access must start at the lane just above the previous access's highest lane, and the enabled lanes of any access must be contiguous. Example: lanes 0, then 1, then 2-3 is legal.
- R4: An access that breaks R3 (an all-zero enable counts as a break) sets `bad_access`. It stores nothing, and it leaves the pointer and the expected next lane unchanged. Example: lanes 0, then 1, then 3 alone.
- R5: The pointer advances by one word exactly when an accepted access covers lane 3, or meets the rule in R6. Otherwise the next access goes to the same word.
- R6: `xfer_bytes` (1 to 1024) sets the block length. The last word is word (xfer_bytes-1)/4 and its final lane is (xfer_bytes-1) mod 4. An accepted access on that word that reaches or passes that lane advances the pointer and ends the block. After the end, every access is refused.
- R7: `buf_wr_en` is 1 only when all of these hold: the transfer direction is write (`xfer_dir`=0), the block has not ended, and the current half is owned by the host. A write while it is 0 sets `bad_access` and stores nothing.
- R8: `buf_rd_en` is 1 only when all of these hold: the direction is read (`xfer_dir`=1), the block has not ended, and the current half is owned by the host. A read while it is 0 sets `bad_access`, and its response carries data 0.
- R9: When the pointer advances off the last word of a half (word 127 or 255) or off the block's last word, that half's `half_to_card` bit (bit 0 = words 0-127, bit 1 = words 128-255) goes to 1 on the next cycle. A `card_done` pulse on that bit returns the half to the host.
- R10: A `xfer_start` pulse sets the pointer to word 0 and the expected lane to 0, and clears the block-end state. In write direction both halves go to the host (`half_to_card`=00). In read direction both go to the card side (`half_to_card`=11).
- R11: `bad_access` stays 1 until a cycle with `bad_clr` high and no new refused access. A refused access in the same cycle as `bad_clr` keeps the flag at 1.
- R12: Every read access gives `host_rsp_valid` high for one cycle, on the cycle after the access. The response data holds the enabled lanes of the current word and zeros in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Pulse: begin a new block |
| xfer_dir | input | 1 | Direction of the block: 0 host writes, 1 host reads |
| xfer_bytes | input | 11 | Block length in bytes (1 to 1024), sampled while the block runs |
| host_valid | input | 1 | Host access in this cycle |
| host_write | input | 1 | 1 write, 0 read |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Write data, little endian lanes |
| host_rsp_valid | output | 1 | Read response valid |
| host_rdata | output | 32 | Read response data |
| buf_wr_en | output | 1 | Host write currently allowed |
| buf_rd_en | output | 1 | Host read currently allowed |
| bad_access | output | 1 | Sticky refused-access flag |
| bad_clr | input | 1 | Clear for `bad_access` |
| half_to_card | output | 2 | Half currently owned by the card side |
| card_done | input | 2 | Pulse: card side returns that half |
| card_addr | input | 8 | Card-side word address |
| card_we | input | 1 | Card-side word write |
| card_wdata | input | 32 | Card-side write data |
| card_rdata | output | 32 | Card-side read data, combinational from `card_addr` |

## Verification
The bench targets the lane-order edges. It runs both legal narrow patterns and then a pattern that skips lane 2. A design that accepted the skip would leave garbage in lane 3 and move the pointer, so the next full word would land one word too far. A design that advanced on any access would scatter bytes across words. The bench checks block ends that fall short of lane 3: a design that waited for lane 3 would never hand the half over. It also checks the exact word where a half is handed to the card side and read accesses made before the card has filled the buffer. Stored values are read back through the card port, so a write that slipped past the enables shows up as altered memory.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DW     = LANES * 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;

  function automatic logic [LANE_W-1:0] lo_lane(input logic [LANES-1:0] be);
    lo_lane = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (be[i]) lo_lane = LANE_W'(i);
  endfunction

  function automatic logic [LANE_W-1:0] hi_lane(input logic [LANES-1:0] be);
    hi_lane = '0;
    for (int i = 0; i < LANES; i++)
      if (be[i]) hi_lane = LANE_W'(i);
  endfunction

  function automatic logic is_contig(input logic [LANES-1:0] be);
    logic [LANES-1:0] span;
    logic [LANE_W-1:0] lo, hi;
    lo = lo_lane(be);
    hi = hi_lane(be);
    for (int i = 0; i < LANES; i++)
      span[i] = (LANE_W'(i) >= lo) && (LANE_W'(i) <= hi);
    is_contig = (be != '0) && (be == span);
  endfunction
endpackage

// File: rtl/xbb_lane_seq.sv
module xbb_lane_seq
  import xbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req,
  input  logic [LANES-1:0]  be,
  input  logic              at_last,
  input  logic [LANE_W-1:0] last_lane,
  output logic              ok_seq,
  output logic              advance
);
  logic [LANE_W-1:0] nxt_lane;
  logic [LANE_W-1:0] lo, hi;
  logic              reach;

  assign lo     = lo_lane(be);
  assign hi     = hi_lane(be);
  assign ok_seq = is_contig(be) && (lo == nxt_lane);
  assign reach  = (hi == LANE_W'(LANES - 1)) || (at_last && hi >= last_lane);
  assign advance = req && ok_seq && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              nxt_lane <= '0;
    else if (start)          nxt_lane <= '0;
    else if (req && ok_seq)  nxt_lane <= reach ? '0 : hi + 1'b1;
  end

  // R5
  adv_clears_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> nxt_lane == '0);
  // R4
  bad_seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ok_seq && !start |=> $stable(nxt_lane));
endmodule

// File: rtl/xbb_half_ctl.sv
module xbb_half_ctl
  import xbb_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BLEN_W = $clog2(DEPTH * LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [BLEN_W-1:0] blen,
  input  logic              advance,
  input  logic [1:0]        card_done,
  output logic [ADDR_W-1:0] ptr,
  output logic [1:0]        host_own,
  output logic              blk_end,
  output logic              at_last,
  output logic [LANE_W-1:0] last_lane
);
  logic [BLEN_W-1:0] blen_m1;
  logic [ADDR_W-1:0] last_word;
  logic              half_end;
  logic              cur_half;

  assign blen_m1   = blen - 1'b1;
  assign last_word = blen_m1[ADDR_W+LANE_W-1:LANE_W];
  assign last_lane = blen_m1[LANE_W-1:0];
  assign at_last   = (ptr == last_word);
  assign half_end  = &ptr[ADDR_W-2:0];
  assign cur_half  = ptr[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      blk_end <= 1'b1;
    end else if (start) begin
      ptr     <= '0;
      blk_end <= 1'b0;
    end else if (advance) begin
      ptr <= ptr + 1'b1;
      if (at_last) blk_end <= 1'b1;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        host_own[h] <= 1'b1;
      else if (start)
        host_own[h] <= (dir == DIR_WR);
      else if (advance && cur_half == h[0] && (half_end || at_last))
        host_own[h] <= 1'b0;
      else if (card_done[h] && !host_own[h])
        host_own[h] <= 1'b1;
    end

    // R9
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !start && cur_half == h[0] && (half_end || at_last) |=> !host_own[h]);
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !start |=> $stable(ptr));
  // R10
  start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ptr == '0 && !blk_end);
endmodule

// File: rtl/xbb_store.sv
module xbb_store
  import xbb_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [LANES-1:0]  host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              card_we,
  input  logic [ADDR_W-1:0] card_addr,
  input  logic [DW-1:0]     card_wdata,
  output logic [DW-1:0]     card_rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bytes [DEPTH];

    always_ff @(posedge clk) begin
      if (card_we)
        bytes[card_addr] <= card_wdata[8*l +: 8];
      if (host_we && host_be[l])
        bytes[host_addr] <= host_wdata[8*l +: 8];
    end

    assign host_rdata[8*l +: 8] = bytes[host_addr];
    assign card_rdata[8*l +: 8] = bytes[card_addr];
  end
endmodule

// File: rtl/xfer_byte_buffer.sv
module xfer_byte_buffer
  import xbb_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BLEN_W = $clog2(DEPTH * LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_dir,
  input  logic [BLEN_W-1:0] xfer_bytes,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [LANES-1:0]  host_be,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_rsp_valid,
  output logic [DW-1:0]     host_rdata,
  output logic              buf_wr_en,
  output logic              buf_rd_en,
  output logic              bad_access,
  input  logic              bad_clr,
  output logic [1:0]        half_to_card,
  input  logic [1:0]        card_done,
  input  logic [ADDR_W-1:0] card_addr,
  input  logic              card_we,
  input  logic [DW-1:0]     card_wdata,
  output logic [DW-1:0]     card_rdata
);
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        host_own;
  logic              blk_end, at_last;
  logic [LANE_W-1:0] last_lane;
  logic              allowed, req, ok_seq, advance, refuse;
  logic [DW-1:0]     word_rd, lane_mask;

  assign buf_wr_en = !blk_end && (xfer_dir == DIR_WR) && host_own[ptr[ADDR_W-1]];
  assign buf_rd_en = !blk_end && (xfer_dir == DIR_RD) && host_own[ptr[ADDR_W-1]];
  assign allowed   = host_write ? buf_wr_en : buf_rd_en;
  assign req       = host_valid && allowed;
  assign refuse    = host_valid && !(allowed && ok_seq);
  assign half_to_card = ~host_own;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[8*l +: 8] = {8{host_be[l]}};
  end

  xbb_lane_seq u_seq (
    .clk, .rst_n, .start(xfer_start), .req, .be(host_be),
    .at_last, .last_lane, .ok_seq, .advance
  );

  xbb_half_ctl #(.DEPTH(DEPTH)) u_half (
    .clk, .rst_n, .start(xfer_start), .dir(xfer_dir), .blen(xfer_bytes),
    .advance, .card_done, .ptr, .host_own, .blk_end, .at_last, .last_lane
  );

  xbb_store #(.DEPTH(DEPTH)) u_store (
    .clk,
    .host_we(req && ok_seq && host_write), .host_be, .host_addr(ptr),
    .host_wdata, .host_rdata(word_rd),
    .card_we, .card_addr, .card_wdata, .card_rdata
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      host_rdata     <= '0;
      bad_access     <= 1'b0;
    end else begin
      host_rsp_valid <= host_valid && !host_write;
      if (host_valid && !host_write)
        host_rdata <= (req && ok_seq) ? (word_rd & lane_mask) : '0;
      if (refuse)       bad_access <= 1'b1;
      else if (bad_clr) bad_access <= 1'b0;
    end
  end

  // R7
  wr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_write && !buf_wr_en |=> bad_access);
  // R8
  rd_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_write && !buf_rd_en |=> bad_access && host_rdata == '0);
  // R11
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access && !bad_clr |=> bad_access);
  // R12
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_write |=> host_rsp_valid);
endmodule

// File: tb/xfer_byte_buffer_bench.sv
module xfer_byte_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 0, xfer_dir = 0;
  logic [10:0] xfer_bytes = 11'd1024;
  logic        host_valid = 0, host_write = 0;
  logic [3:0]  host_be = 0;
  logic [31:0] host_wdata = 0;
  logic        host_rsp_valid;
  logic [31:0] host_rdata;
  logic        buf_wr_en, buf_rd_en, bad_access;
  logic        bad_clr = 0;
  logic [1:0]  half_to_card;
  logic [1:0]  card_done = 0;
  logic [7:0]  card_addr = 0;
  logic        card_we = 0;
  logic [31:0] card_wdata = 0, card_rdata;

  int checks = 0, errors = 0;

  always #5ns clk = ~clk;

  xfer_byte_buffer u_xfer_byte_buffer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(logic wr, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_write = wr; host_be = be; host_wdata = d;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic start(logic dir, logic [10:0] n);
    @(negedge clk);
    xfer_start = 1; xfer_dir = dir; xfer_bytes = n;
    @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic card_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    card_we = 1; card_addr = a; card_wdata = d;
    @(negedge clk);
    card_we = 0;
  endtask

  task automatic card_rd(logic [7:0] a, output logic [31:0] d);
    card_addr = a;
    #1ns;
    d = card_rdata;
  endtask

  task automatic done(int h);
    @(negedge clk);
    card_done[h] = 1;
    @(negedge clk);
    card_done = 0;
  endtask

  task automatic clear_bad();
    @(negedge clk);
    bad_clr = 1;
    @(negedge clk);
    bad_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 bad", bad_access, 0);
    chk("R1 h2c", half_to_card, 0);
    chk("R1 rsp", host_rsp_valid, 0);
    chk("R1 wr_en", buf_wr_en, 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    start(0, 11'd1024);
    chk("R10 h2c write", half_to_card, 2'b00);
    acc(1, 4'b0001, 32'h000000AA);
    acc(1, 4'b0010, 32'h0000BB00);
    acc(1, 4'b1100, 32'hDDCC0000);
    acc(1, 4'b0001, 32'h00000011);
    acc(1, 4'b0010, 32'h00002200);
    acc(1, 4'b0100, 32'h00330000);
    acc(1, 4'b1000, 32'h44000000);
    acc(1, 4'b1111, 32'h12345678);
    chk("R3 no bad", bad_access, 0);
    card_rd(0, d); chk("R2 R3 word0", d, 32'hDDCCBBAA);
    card_rd(1, d); chk("R3 R5 word1", d, 32'h44332211);
    card_rd(2, d); chk("R5 word2", d, 32'h12345678);
  endtask

  task automatic t_violation();
    logic [31:0] d;
    card_wr(3, 32'hEEEEEEEE);
    acc(1, 4'b0001, 32'h00000001);
    acc(1, 4'b0010, 32'h00000200);
    acc(1, 4'b1000, 32'h78000000);
    chk("R4 bad set", bad_access, 1);
    card_rd(3, d); chk("R4 not stored", d, 32'hEEEE0201);
    acc(1, 4'b0100, 32'h00030000);
    acc(1, 4'b1000, 32'h04000000);
    acc(1, 4'b1111, 32'hCAFE0004);
    card_rd(3, d); chk("R4 lane state kept", d, 32'h04030201);
    card_rd(4, d); chk("R4 R5 ptr kept", d, 32'hCAFE0004);
    @(negedge clk);
    chk("R11 sticky", bad_access, 1);
    clear_bad();
    chk("R11 cleared", bad_access, 0);
  endtask

  task automatic t_handoff();
    logic [31:0] d;
    for (int w = 5; w < 127; w++) acc(1, 4'b1111, 32'(w));
    chk("R9 not yet", half_to_card, 2'b00);
    acc(1, 4'b1111, 32'h0000007F);
    chk("R9 half0 out", half_to_card, 2'b01);
    chk("R7 half1 wr_en", buf_wr_en, 1);
    acc(1, 4'b1111, 32'hB0B0B0B0);
    chk("R9 half1 ok", bad_access, 0);
    done(0);
    chk("R9 half0 back", half_to_card, 2'b00);
    card_rd(128, d); chk("R9 word128", d, 32'hB0B0B0B0);
  endtask

  task automatic t_wr_disabled();
    logic [31:0] d;
    card_wr(2, 32'h5A5A5A5A);
    start(0, 11'd8);
    acc(1, 4'b1111, 32'h01010101);
    acc(1, 4'b1111, 32'h02020202);
    chk("R6 R9 end handoff", half_to_card, 2'b01);
    chk("R7 wr_en off", buf_wr_en, 0);
    acc(1, 4'b1111, 32'h99999999);
    chk("R7 bad", bad_access, 1);
    card_rd(2, d); chk("R7 no store", d, 32'h5A5A5A5A);
    clear_bad();
  endtask

  task automatic t_short_block();
    logic [31:0] d;
    start(0, 11'd6);
    acc(1, 4'b1111, 32'hA0A1A2A3);
    chk("R6 mid", half_to_card, 2'b00);
    acc(1, 4'b0011, 32'h0000B1B2);
    chk("R6 lane1 ends", half_to_card, 2'b01);
    chk("R6 wr_en off", buf_wr_en, 0);
    chk("R6 no bad", bad_access, 0);
    card_rd(1, d); chk("R6 word1 low", d[15:0], 32'h0000B1B2);
  endtask

  task automatic t_read();
    start(1, 11'd8);
    chk("R10 h2c read", half_to_card, 2'b11);
    chk("R8 rd_en off", buf_rd_en, 0);
    acc(0, 4'b1111, 0);
    chk("R8 bad", bad_access, 1);
    chk("R12 rsp refused", host_rsp_valid, 1);
    chk("R8 data zero", host_rdata, 0);
    clear_bad();
    card_wr(0, 32'hA1B2C3D4);
    card_wr(1, 32'h0F1E2D3C);
    done(0);
    chk("R8 rd_en on", buf_rd_en, 1);
    acc(0, 4'b0011, 0);
    chk("R12 rsp", host_rsp_valid, 1);
    chk("R12 low lanes", host_rdata, 32'h0000C3D4);
    @(negedge clk);
    chk("R12 one cycle", host_rsp_valid, 0);
    acc(0, 4'b1100, 0);
    chk("R12 high lanes", host_rdata, 32'hA1B20000);
    acc(0, 4'b1111, 0);
    chk("R12 word1", host_rdata, 32'h0F1E2D3C);
    chk("R6 R9 read end", half_to_card, 2'b11);
    chk("R8 rd_en end", buf_rd_en, 0);
    chk("R8 no bad", bad_access, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    start(0, 11'd1024);
    acc(1, 4'b0001, 32'h000000EE);
    start(0, 11'd1024);
    acc(1, 4'b1111, 32'h600D600D);
    chk("R10 lane reset", bad_access, 0);
    card_rd(0, d); chk("R10 ptr reset", d, 32'h600D600D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_violation();
    t_handoff();
    t_wr_disabled();
    t_short_block();
    t_read();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule